// File: doc/BRIEF.md
# Priority Reference Selector with Revertive Switching

This block decides which one of eight timing reference inputs drives a downstream clock loop. Each reference carries a small configuration word: a 3-bit rank (0 is the best rank, 7 the worst) and a revertive flag. When read back, the word is extended with a 4-bit detected-frequency code that is supplied from outside. A reference is usable when three qualifiers supplied from outside all hold: its signal is present, it is not masked, and its frequency offset is within limits.

In automatic mode the selection is re-evaluated every cycle and the result is registered. The current reference is kept while it stays usable. When it is lost, the best usable reference takes over. Equal ranks are resolved in favour of the lower reference number. A better-ranked reference that becomes usable pre-empts the current one only if the current one has its revertive flag set. When no reference is usable, a holdover flag is raised and the last index is kept. Each change of the selected index produces a one-cycle pulse that can feed an interrupt event. In manual mode an external index is forced and rank writes are refused. The revertive flag stays writable in manual mode.

Top module: `ref_priority_selector`

## Requirements
- R1: While reset is asserted, `active_ref` is 0, `holdover` is 0 and `active_change` is 0. Every stored rank and revertive flag is 0.
- R2: Reference i is usable only when `sig_present[i]`=1, `ref_mask[i]`=0 and `offset_ok[i]`=1. Clearing any one of the three qualifiers disqualifies it.
- R3: In automatic mode, when the selected reference is not usable and some other reference is usable, the block selects the usable reference with the numerically smallest rank.
- R4: When usable references share the best rank, the one with the lowest index is chosen. This also decides whether a candidate outranks the selected reference.
- R5: In automatic mode, a usable reference that outranks the selected, still-usable reference is switched to only when the selected reference's revertive flag is 1.
- R6: In automatic mode, while the selected reference is usable and its revertive flag is 0, the selection does not change.
- R7: When no reference is usable, `holdover` is 1 and, in automatic mode, `active_ref` keeps its value. When references return, the best usable one is selected and `holdover` returns to 0.
- R8: `active_change` is 1 for exactly the cycle in which `active_ref` shows a new value, and 0 otherwise.
- R9: With `manual_mode`=1, `active_ref` follows `manual_sel` regardless of usability. Writes leave the rank bits unchanged but still update the revertive flag. On return to automatic mode the rules of R3 to R6 apply to the reference held at that moment.
- R10: `cfg_rdata` for reference `cfg_addr` is formatted as follows: bits 7:4 are that reference's slice of `freq_code`, bit 3 is the revertive flag (1 = revertive), and bits 2:0 are the rank. A write with `cfg_wr_en`=1 takes bit 3 of `cfg_wdata` as the revertive flag and bits 2:0 as the rank.
- R11: Selection is registered. A change on the qualifiers or the mode becomes visible on `active_ref` after the next rising clock edge, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sig_present | input | 8 | Per-reference signal-present qualifier |
| ref_mask | input | 8 | Per-reference mask, 1 disqualifies |
| offset_ok | input | 8 | Per-reference frequency-offset-acceptable qualifier |
| freq_code | input | 32 | Detected-frequency codes, 4 bits per reference, reference i at bits 4i+3:4i |
| manual_mode | input | 1 | 1 forces manual selection and locks ranks |
| manual_sel | input | 3 | Reference index forced in manual mode |
| cfg_wr_en | input | 1 | Write strobe for the configuration word at `cfg_addr` |
| cfg_addr | input | 3 | Reference index for configuration write and read |
| cfg_wdata | input | 4 | Write data: bit 3 revertive, bits 2:0 rank |
| cfg_rdata | output | 8 | Read data: frequency code, revertive flag, rank |
| active_ref | output | 3 | Registered index of the selected reference |
| holdover | output | 1 | 1 while no reference is usable |
| active_change | output | 1 | One-cycle pulse on a change of `active_ref` |

## Verification
The bench goes after the tie between two references that share a rank. A design that compares ranks with less-or-equal would pick the higher index there, and would also let a tied, higher-numbered candidate pre-empt the current reference. It checks that a better reference returning under a non-revertive selection is ignored; a design that ignored the revertive flag would jump to it at once. It also checks that a revertive flag written one cycle earlier takes effect on the following edge. It drives an empty usable set and then a recovery. A design that cleared the index during holdover, or that missed the loss of the held reference on recovery, would show the wrong index or no change pulse. Manual mode is checked with a rank write that must be refused while the revertive bit lands, and with the release back to automatic selection.

// File: rtl/ref_sel_pkg.sv
package ref_sel_pkg;

    localparam int DEF_NUM_REFS = 8;
    localparam int DEF_PRIO_W   = 3;
    localparam int DEF_FREQ_W   = 4;

    typedef enum logic [0:0] {
        SEL_AUTO   = 1'b0,
        SEL_MANUAL = 1'b1
    } sel_mode_e;

endpackage

// File: rtl/ref_cfg_bank.sv
module ref_cfg_bank #(
    parameter int NUM_REFS = ref_sel_pkg::DEF_NUM_REFS,
    parameter int PRIO_W   = ref_sel_pkg::DEF_PRIO_W,
    parameter int FREQ_W   = ref_sel_pkg::DEF_FREQ_W,
    parameter int IDX_W    = $clog2(NUM_REFS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       manual_mode,
    input  logic                       wr_en,
    input  logic [IDX_W-1:0]           addr,
    input  logic [PRIO_W:0]            wdata,
    input  logic [NUM_REFS*FREQ_W-1:0] freq_codes,
    output logic [FREQ_W+PRIO_W:0]     rdata,
    output logic [NUM_REFS*PRIO_W-1:0] prio_flat,
    output logic [NUM_REFS-1:0]        rev_vec
);

    localparam bit ADDR_FULL = (NUM_REFS == (1 << IDX_W));

    typedef struct packed {
        logic [NUM_REFS-1:0][PRIO_W-1:0] prio;
        logic [NUM_REFS-1:0]             rev;
    } bank_t;

    bank_t bank_d, bank_q;
    logic  addr_ok;

    assign addr_ok = ADDR_FULL || (int'(addr) < NUM_REFS);

    always_comb begin
        bank_d = bank_q;
        if (wr_en && addr_ok) begin
            bank_d.rev[addr] = wdata[PRIO_W];
            if (!manual_mode) begin
                bank_d.prio[addr] = wdata[PRIO_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    always_comb begin
        rdata = '0;
        if (addr_ok) begin
            rdata = {freq_codes[int'(addr)*FREQ_W +: FREQ_W],
                     bank_q.rev[addr], bank_q.prio[addr]};
        end
    end

    assign prio_flat = bank_q.prio;
    assign rev_vec   = bank_q.rev;

    AST_PRIO_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        $past(manual_mode) |-> (bank_q.prio == $past(bank_q.prio))); // R9

endmodule

// File: rtl/ref_rank_scan.sv
module ref_rank_scan #(
    parameter int NUM_REFS = ref_sel_pkg::DEF_NUM_REFS,
    parameter int PRIO_W   = ref_sel_pkg::DEF_PRIO_W,
    parameter int IDX_W    = $clog2(NUM_REFS)
) (
    input  logic [NUM_REFS-1:0]        usable,
    input  logic [NUM_REFS*PRIO_W-1:0] prio_flat,
    output logic                       found,
    output logic [IDX_W-1:0]           best_idx,
    output logic [PRIO_W-1:0]          best_prio
);

    // Ascending scan; a strict compare keeps the lower index on equal rank.
    always_comb begin
        found     = 1'b0;
        best_idx  = '0;
        best_prio = '1;
        for (int i = 0; i < NUM_REFS; i++) begin
            if (usable[i] &&
                (!found || (prio_flat[i*PRIO_W +: PRIO_W] < best_prio))) begin
                found     = 1'b1;
                best_idx  = IDX_W'(i);
                best_prio = prio_flat[i*PRIO_W +: PRIO_W];
            end
        end
    end

endmodule

// File: rtl/ref_priority_selector.sv
module ref_priority_selector #(
    parameter int NUM_REFS = ref_sel_pkg::DEF_NUM_REFS,
    parameter int PRIO_W   = ref_sel_pkg::DEF_PRIO_W,
    parameter int FREQ_W   = ref_sel_pkg::DEF_FREQ_W,
    parameter int IDX_W    = $clog2(NUM_REFS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_REFS-1:0]        sig_present,
    input  logic [NUM_REFS-1:0]        ref_mask,
    input  logic [NUM_REFS-1:0]        offset_ok,
    input  logic [NUM_REFS*FREQ_W-1:0] freq_code,
    input  logic                       manual_mode,
    input  logic [IDX_W-1:0]           manual_sel,
    input  logic                       cfg_wr_en,
    input  logic [IDX_W-1:0]           cfg_addr,
    input  logic [PRIO_W:0]            cfg_wdata,
    output logic [FREQ_W+PRIO_W:0]     cfg_rdata,
    output logic [IDX_W-1:0]           active_ref,
    output logic                       holdover,
    output logic                       active_change
);

    import ref_sel_pkg::*;

    localparam bit SEL_FULL = (NUM_REFS == (1 << IDX_W));

    typedef struct packed {
        logic [IDX_W-1:0] active;
        logic             holdover;
        logic             change;
    } sel_state_t;

    sel_state_t st_d, st_q;

    logic [NUM_REFS-1:0]        usable;
    logic [NUM_REFS*PRIO_W-1:0] prio_flat;
    logic [NUM_REFS-1:0]        rev_vec;
    logic                       found;
    logic [IDX_W-1:0]           best_idx;
    logic [PRIO_W-1:0]          best_prio;
    logic [PRIO_W-1:0]          act_prio;
    logic                       outranked;
    logic                       sel_ok;
    sel_mode_e                  mode;

    // Per-reference qualification
    for (genvar g = 0; g < NUM_REFS; g++) begin : g_qual
        assign usable[g] = sig_present[g] & ~ref_mask[g] & offset_ok[g];
    end

    assign mode   = manual_mode ? SEL_MANUAL : SEL_AUTO;
    assign sel_ok = SEL_FULL || (int'(manual_sel) < NUM_REFS);

    ref_cfg_bank #(
        .NUM_REFS (NUM_REFS),
        .PRIO_W   (PRIO_W),
        .FREQ_W   (FREQ_W),
        .IDX_W    (IDX_W)
    ) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .manual_mode (manual_mode),
        .wr_en       (cfg_wr_en),
        .addr        (cfg_addr),
        .wdata       (cfg_wdata),
        .freq_codes  (freq_code),
        .rdata       (cfg_rdata),
        .prio_flat   (prio_flat),
        .rev_vec     (rev_vec)
    );

    ref_rank_scan #(
        .NUM_REFS (NUM_REFS),
        .PRIO_W   (PRIO_W),
        .IDX_W    (IDX_W)
    ) u_scan (
        .usable    (usable),
        .prio_flat (prio_flat),
        .found     (found),
        .best_idx  (best_idx),
        .best_prio (best_prio)
    );

    assign act_prio  = prio_flat[int'(st_q.active)*PRIO_W +: PRIO_W];
    assign outranked = (best_prio < act_prio) ||
                       ((best_prio == act_prio) && (best_idx < st_q.active));

    always_comb begin
        st_d          = st_q;
        st_d.holdover = !found;
        unique case (mode)
            SEL_MANUAL: begin
                if (sel_ok) begin
                    st_d.active = manual_sel;
                end
            end
            default: begin
                if (found) begin
                    if (!usable[st_q.active]) begin
                        st_d.active = best_idx;
                    end else if (rev_vec[st_q.active] && outranked) begin
                        st_d.active = best_idx;
                    end
                end
            end
        endcase
        st_d.change = (st_d.active != st_q.active);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active_ref    = st_q.active;
    assign holdover      = st_q.holdover;
    assign active_change = st_q.change;

    AST_SCAN_PICKS_USABLE: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> usable[best_idx]); // R3

    AST_PULSE_MEANS_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        active_change |-> (active_ref != $past(active_ref))); // R8

    AST_NO_PULSE_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        !active_change |-> $stable(active_ref)); // R8

    AST_HOLDOVER_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (holdover && !$past(manual_mode)) |-> (active_ref == $past(active_ref))); // R7

    AST_NONREV_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(manual_mode) && $past(usable[st_q.active]) && !$past(rev_vec[st_q.active]))
            |-> $stable(active_ref)); // R6

endmodule

// File: tb/sim_ref_priority_selector.sv
module sim_ref_priority_selector;

    localparam int N  = 8;
    localparam int PW = 3;
    localparam int FW = 4;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  sig_present = '1;
    logic [N-1:0]  ref_mask = '0;
    logic [N-1:0]  offset_ok = '1;
    logic [N*FW-1:0] freq_code;
    logic          manual_mode = 1'b0;
    logic [IW-1:0] manual_sel = '0;
    logic          cfg_wr_en = 1'b0;
    logic [IW-1:0] cfg_addr = '0;
    logic [PW:0]   cfg_wdata = '0;
    logic [FW+PW:0] cfg_rdata;
    logic [IW-1:0] active_ref;
    logic          holdover;
    logic          active_change;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    initial begin
        for (int i = 0; i < N; i++) freq_code[i*FW +: FW] = FW'(i + 1);
    end

    ref_priority_selector u0 (
        .clk(clk), .rst_n(rst_n), .sig_present(sig_present), .ref_mask(ref_mask),
        .offset_ok(offset_ok), .freq_code(freq_code), .manual_mode(manual_mode),
        .manual_sel(manual_sel), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .active_ref(active_ref),
        .holdover(holdover), .active_change(active_change)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic sel_is(input string req, input int idx, input int chg, input int hold);
        chk({req, " active_ref"}, int'(active_ref), idx);
        chk({req, " active_change"}, int'(active_change), chg);
        chk({req, " holdover"}, int'(holdover), hold);
    endtask

    task automatic write_cfg(input int idx, input bit rev, input int prio);
        cfg_addr  = IW'(idx);
        cfg_wdata = {rev, PW'(prio)};
        cfg_wr_en = 1'b1;
        step();
        cfg_wr_en = 1'b0;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        cfg_addr = 3'd3;
        #1;
        sel_is("R1 in reset", 0, 0, 0);
        chk("R1 R10 reset word ref3", int'(cfg_rdata), 8'h40);
        rst_n = 1'b1;
        step();
        sel_is("R1 after release", 0, 0, 0);
    endtask

    task automatic t_config();
        write_cfg(0, 0, 4); write_cfg(1, 0, 2); write_cfg(2, 0, 2); write_cfg(3, 0, 5);
        write_cfg(4, 0, 1); write_cfg(5, 0, 6); write_cfg(6, 0, 3); write_cfg(7, 0, 1);
        cfg_addr = 3'd5;
        #1;
        chk("R10 readback ref5", int'(cfg_rdata), 8'h66);
        step(); step();
        sel_is("R6 better ref ignored while non-revertive", 0, 0, 0);
    endtask

    task automatic t_failover();
        ref_mask[0] = 1'b1;
        #1;
        chk("R11 no change before edge", int'(active_ref), 0);
        step();
        sel_is("R2 R3 R4 mask loss picks lower index on tie", 4, 1, 0);
        step();
        sel_is("R8 pulse lasts one cycle", 4, 0, 0);
        offset_ok[4] = 1'b0;
        step();
        sel_is("R2 R3 offset loss", 7, 1, 0);
    endtask

    task automatic t_revert();
        write_cfg(7, 1, 1);
        sel_is("R5 no candidate yet", 7, 0, 0);
        offset_ok[4] = 1'b1;
        step();
        sel_is("R5 R4 revertive tie-break pre-empt", 4, 1, 0);
        ref_mask[0] = 1'b0;
        step();
        sel_is("R5 worse returning ref ignored", 4, 0, 0);
    endtask

    task automatic t_nonrev();
        write_cfg(1, 0, 0);
        step(); step();
        sel_is("R6 outranked but non-revertive", 4, 0, 0);
        write_cfg(4, 1, 1);
        sel_is("R5 flag not yet effective", 4, 0, 0);
        step();
        sel_is("R5 flag effective next edge", 1, 1, 0);
    endtask

    task automatic t_holdover();
        sig_present = '0;
        step();
        sel_is("R7 enter holdover", 1, 0, 1);
        step();
        sel_is("R7 holdover held", 1, 0, 1);
        sig_present = 8'b0000_1100;
        step();
        sel_is("R7 recovery to best", 2, 1, 0);
        offset_ok[2] = 1'b0;
        step();
        sel_is("R2 offset fail moves on", 3, 1, 0);
    endtask

    task automatic t_manual();
        manual_mode = 1'b1;
        manual_sel  = 3'd6;
        step();
        sel_is("R9 manual force", 6, 1, 0);
        write_cfg(6, 1, 0);
        cfg_addr = 3'd6;
        #1;
        chk("R9 R10 rank locked, flag written", int'(cfg_rdata), 8'h7B);
        step();
        sel_is("R9 manual holds unusable ref", 6, 0, 0);
        manual_mode = 1'b0;
        step();
        sel_is("R9 R3 release to auto", 3, 1, 0);
    endtask

    initial begin
        t_reset();
        t_config();
        t_failover();
        t_revert();
        t_nonrev();
        t_holdover();
        t_manual();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R11 watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule